// File: doc/BRIEF.md
# SPI master serial engine

This block is the serial core of a master-only SPI controller. It pulls 8-bit frames from a show-ahead transmit FIFO and shifts each one out on the data-out pin, most significant bit first. On the same serial clock it samples the data-in pin and pushes exactly one received byte into a receive FIFO for every byte it sends. The FIFOs and the register decode sit outside; this block sees only their level flags, data and pop/push strobes.

The serial clock comes from the core clock through an even divider. Clock polarity and phase are set by two configuration inputs. A global enable gates the engine: dropping it abandons any frame in flight and returns the serial clock to its idle level. The chip-select lines come from a select mask that is not tied to frame timing, so software can hold a slave selected across many frames. A busy output reports a frame in progress or bytes still waiting in the transmit FIFO.

Top module: `spi_master_engine`

## Requirements
- R1: The serial clock half-period is max(1, clk_div >> 1) core cycles; bit 0 of clk_div has no effect and a value of 0 or 1 gives the fastest rate, core clock divided by 2.
- R2: Whenever no frame is being shifted, sclk rests at the level of cpol (low for cpol=0, high for cpol=1).
- R3: With cpha=0 the first data bit is on mosi before the first sclk edge and miso is sampled on the odd (leading) edges; with cpha=1 mosi changes on leading edges and miso is sampled on the even (trailing) edges.
- R4: Each frame is 8 bits, sent most significant bit first, and spans exactly 16 sclk edges.
- R5: Every byte popped and fully shifted gives exactly one rx_push, with rx_data holding the 8 bits sampled from miso, first-sampled bit in bit 7.
- R6: cs_n[n] is driven low one cycle after enable and cs_mask[n] are both 1, and high otherwise; frame activity does not change it.
- R7: Driving enable low abandons the current frame: from the next cycle sclk is at its idle level and the abandoned frame is never pushed.
- R8: busy is 1 while a frame is in progress (including a completed frame waiting to be pushed) or while tx_empty is 0, and 0 otherwise.
- R9: When the transmit FIFO runs empty the engine stops at a byte boundary with sclk idle, and back-to-back bytes are sent in FIFO order.
- R10: While rx_full is 1 no new frame starts (no tx_pop, no sclk edge), and a finished frame waits without pushing until rx_full is 0; no received byte is lost.
- R11: After reset sclk equals cpol, cs_n is all ones, and tx_pop and rx_push are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Global engine enable |
| cpol | input | 1 | Clock polarity: 1 gives idle-high sclk |
| cpha | input | 1 | Clock phase: 1 samples on the second edge |
| clk_div | input | 16 | Divide value; bit 0 ignored, minimum effective 2 |
| cs_mask | input | 2 | Slave select mask, bit n selects slave n |
| tx_empty | input | 1 | Transmit FIFO empty flag |
| tx_data | input | 8 | Transmit FIFO head byte (show-ahead) |
| tx_pop | output | 1 | Pop strobe to the transmit FIFO |
| rx_full | input | 1 | Receive FIFO full flag |
| rx_push | output | 1 | Push strobe to the receive FIFO |
| rx_data | output | 8 | Received byte, valid with rx_push |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 2 | Active-low chip selects |
| busy | output | 1 | Frame in progress or transmit data pending |

## Verification
On every cycle the assertions hold the idle sclk level outside frames, the bound on the edge count, the single-cycle spacing of divider ticks at wider settings, the hold of a finished frame while the receive FIFO is full, the return to idle after enable drops and the release of every chip select while disabled. What only the bench scenarios show is the data itself: the received byte under all four polarity and phase settings, the bit order seen by a modelled slave, the measured half-period for even, odd and zero divide values, FIFO ordering across a burst, and that busy and the stall behave as stated when the transmit FIFO is empty or the receive FIFO is full.

// File: rtl/spi_eng_pkg.sv
// Shared parameters and types for the SPI master serial engine.
package spi_eng_pkg;
    parameter int unsigned FRAME_BITS = 8;
    parameter int unsigned DIV_BITS   = 16;
    parameter int unsigned SLAVES     = 2;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SHIFT = 2'd1,
        ENG_HOLD  = 2'd2
    } eng_state_t;
endpackage

// File: rtl/spi_eng_clkdiv.sv
// Half-period tick generator. Produces one tick every max(1, div_val>>1)
// core cycles while run is high; the count restarts whenever run is low.
// Assumes div_val is stable while run is high.
module spi_eng_clkdiv #(
    parameter int unsigned DIV_W = spi_eng_pkg::DIV_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] half_len;
    logic [DIV_W-1:0] cnt;

    // Half period in core cycles: bit 0 dropped, never below one.
    always_comb begin
        half_len = div_val >> 1;
        if (half_len == '0) half_len = DIV_W'(1);
    end

    assign tick = run && (cnt == half_len - DIV_W'(1));

    // Cycle counter within one half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + DIV_W'(1);
    end

    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && half_len > DIV_W'(1)) |=> !tick);
    assert_count_rest_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/spi_eng_shifter.sv
// Frame shifter. Pops one byte from a show-ahead transmit FIFO, runs 16
// serial clock edges, shifts data out MSB first and samples miso, then
// pushes the received byte once the receive FIFO has room.
// Assumes tx_data is valid whenever tx_empty is low.
module spi_eng_shifter
    import spi_eng_pkg::*;
#(
    parameter int unsigned W = FRAME_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         tick,
    input  logic         tx_empty,
    input  logic [W-1:0] tx_data,
    output logic         tx_pop,
    input  logic         rx_full,
    output logic         rx_push,
    output logic [W-1:0] rx_data,
    output logic         sclk,
    output logic         mosi,
    input  logic         miso,
    output logic         shifting,
    output logic         in_frame
);
    localparam int unsigned EDGES  = 2 * W;
    localparam int unsigned EDGE_W = $clog2(EDGES + 1);

    eng_state_t       st;
    logic [W-1:0]     tx_sr;
    logic [W-1:0]     rx_sr;
    logic [EDGE_W-1:0] edge_cnt;
    logic [EDGE_W-1:0] edge_nxt;
    logic             phase;
    logic             lead_edge;
    logic             sample_edge;

    assign edge_nxt    = edge_cnt + EDGE_W'(1);
    assign lead_edge   = edge_nxt[0];
    assign sample_edge = cpha ? !lead_edge : lead_edge;

    assign tx_pop   = (st == ENG_IDLE) && en && !tx_empty && !rx_full;
    assign rx_push  = (st == ENG_HOLD) && en && !rx_full;
    assign rx_data  = rx_sr;
    assign mosi     = tx_sr[W-1];
    assign sclk     = cpol ^ phase;
    assign shifting = (st == ENG_SHIFT);
    assign in_frame = (st != ENG_IDLE);

    // Frame sequencing, shift registers and serial clock phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ENG_IDLE;
            tx_sr    <= '0;
            rx_sr    <= '0;
            edge_cnt <= '0;
            phase    <= 1'b0;
        end else if (!en) begin
            st       <= ENG_IDLE;
            edge_cnt <= '0;
            phase    <= 1'b0;
        end else begin
            case (st)
                ENG_IDLE: if (tx_pop) begin
                    tx_sr    <= tx_data;
                    edge_cnt <= '0;
                    phase    <= 1'b0;
                    st       <= ENG_SHIFT;
                end
                ENG_SHIFT: if (tick) begin
                    phase    <= ~phase;
                    edge_cnt <= edge_nxt;
                    if (sample_edge)
                        rx_sr <= {rx_sr[W-2:0], miso};
                    else if (edge_nxt != EDGE_W'(1))
                        tx_sr <= {tx_sr[W-2:0], 1'b0};
                    if (edge_nxt == EDGE_W'(EDGES)) st <= ENG_HOLD;
                end
                ENG_HOLD: if (!rx_full) st <= ENG_IDLE;
                default: st <= ENG_IDLE;
            endcase
        end
    end

    assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ENG_IDLE) |-> (sclk == cpol));
    assert_edge_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_cnt <= EDGE_W'(EDGES));
    assert_hold_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ENG_HOLD && rx_full && en) |=> (st == ENG_HOLD));
    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st == ENG_IDLE));
    assert_pop_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> (st == ENG_SHIFT && edge_cnt == '0));
endmodule

// File: rtl/spi_eng_csdrv.sv
// Chip-select driver. Registers one active-low select per slave from the
// global enable and the select mask; independent of frame timing.
module spi_eng_csdrv #(
    parameter int unsigned N = spi_eng_pkg::SLAVES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] sel_mask,
    output logic [N-1:0] cs_n
);
    for (genvar i = 0; i < N; i++) begin : g_cs
        // Select line i: low only while enabled and selected.
        always_ff @(posedge clk) begin
            if (!rst_n) cs_n[i] <= 1'b1;
            else        cs_n[i] <= ~(en & sel_mask[i]);
        end
    end

    assert_cs_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (&cs_n));
endmodule

// File: rtl/spi_master_engine.sv
// Top of the SPI master serial engine: divider, frame shifter and
// chip-select driver. busy covers both an active frame and pending bytes.
module spi_master_engine
    import spi_eng_pkg::*;
#(
    parameter int unsigned FRAME_W = FRAME_BITS,
    parameter int unsigned DIV_W   = DIV_BITS,
    parameter int unsigned NUM_CS  = SLAVES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               cpol,
    input  logic               cpha,
    input  logic [DIV_W-1:0]   clk_div,
    input  logic [NUM_CS-1:0]  cs_mask,
    input  logic               tx_empty,
    input  logic [FRAME_W-1:0] tx_data,
    output logic               tx_pop,
    input  logic               rx_full,
    output logic               rx_push,
    output logic [FRAME_W-1:0] rx_data,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso,
    output logic [NUM_CS-1:0]  cs_n,
    output logic               busy
);
    logic half_tick;
    logic shifting;
    logic in_frame;

    spi_eng_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (shifting),
        .div_val (clk_div),
        .tick    (half_tick)
    );

    spi_eng_shifter #(.W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (enable),
        .cpol     (cpol),
        .cpha     (cpha),
        .tick     (half_tick),
        .tx_empty (tx_empty),
        .tx_data  (tx_data),
        .tx_pop   (tx_pop),
        .rx_full  (rx_full),
        .rx_push  (rx_push),
        .rx_data  (rx_data),
        .sclk     (sclk),
        .mosi     (mosi),
        .miso     (miso),
        .shifting (shifting),
        .in_frame (in_frame)
    );

    spi_eng_csdrv #(.N(NUM_CS)) u_cs (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (enable),
        .sel_mask (cs_mask),
        .cs_n     (cs_n)
    );

    assign busy = in_frame || !tx_empty;

    assert_push_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);
    assert_busy_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> busy);
endmodule

// File: tb/spi_master_engine_tb_top.sv
`timescale 1ns/1ps
module spi_master_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic [15:0] clk_div = 16'd2;
    logic [1:0]  cs_mask = 2'b00;
    logic        tx_empty;
    logic [7:0]  tx_data;
    logic        tx_pop;
    logic        rx_full = 1'b0;
    logic        rx_push;
    logic [7:0]  rx_data;
    logic        sclk;
    logic        mosi;
    logic        miso;
    logic [1:0]  cs_n;
    logic        busy;

    always #2 clk = ~clk;

    spi_master_engine dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cpol(cpol), .cpha(cpha),
        .clk_div(clk_div), .cs_mask(cs_mask), .tx_empty(tx_empty),
        .tx_data(tx_data), .tx_pop(tx_pop), .rx_full(rx_full),
        .rx_push(rx_push), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n), .busy(busy)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Transmit FIFO model (show-ahead).
    logic [7:0] txq [16];
    int tx_wr = 0;
    int tx_rd = 0;
    int pop_cnt = 0;
    assign tx_empty = (tx_wr == tx_rd);
    assign tx_data  = txq[tx_rd % 16];
    always @(posedge clk) if (tx_pop) begin
        tx_rd   <= tx_rd + 1;
        pop_cnt <= pop_cnt + 1;
    end

    // Receive FIFO log.
    logic [7:0] rx_log [64];
    int rx_cnt = 0;
    always @(posedge clk) if (rx_push) begin
        rx_log[rx_cnt % 64] <= rx_data;
        rx_cnt <= rx_cnt + 1;
    end

    // Slave model: counts sclk edges, drives miso, captures mosi.
    int s_edges = 0;
    logic [7:0] s_bytes [4];
    logic [7:0] s_rx [4];
    logic [7:0] s_in = 8'h00;
    function automatic int bit_idx(int e, logic ph);
        int m = e % 16;
        if (!ph) return m / 2;
        return (m == 0) ? 0 : (m - 1) / 2;
    endfunction
    assign miso = s_bytes[(s_edges / 16) % 4][7 - bit_idx(s_edges, cpha)];
    always @(sclk) begin
        s_edges = s_edges + 1;
        if ((s_edges % 2 == 1) != cpha) s_in = {s_in[6:0], mosi};
        if (s_edges % 16 == 0 && s_edges / 16 <= 4) s_rx[s_edges / 16 - 1] = s_in;
    end

    // Serial clock half-period measurement in core cycles.
    int since = 0;
    int last_gap = 0;
    logic sclk_prev = 1'b0;
    always @(negedge clk) begin
        if (sclk != sclk_prev) begin
            last_gap = since;
            since = 1;
        end else since = since + 1;
        sclk_prev = sclk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_tx(input logic [7:0] b);
        txq[tx_wr % 16] = b;
        tx_wr = tx_wr + 1;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_rx(input int target, input int limit);
        for (int i = 0; i < limit && rx_cnt < target; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic slave_clear();
        s_edges = 0;
        s_in = 8'h00;
    endtask

    // Vector fields: [33] cpol, [32] cpha, [31:16] divide, [15:8] tx, [7:0] slave.
    localparam int NV = 7;
    localparam logic [33:0] VEC [NV] = '{
        {1'b0, 1'b0, 16'd2, 8'hA5, 8'h3C},
        {1'b0, 1'b1, 16'd4, 8'h5A, 8'hC3},
        {1'b1, 1'b0, 16'd6, 8'h81, 8'h7E},
        {1'b1, 1'b1, 16'd3, 8'hF0, 8'h0F},
        {1'b0, 1'b0, 16'd0, 8'h01, 8'h80},
        {1'b1, 1'b0, 16'd9, 8'h96, 8'h69},
        {1'b0, 1'b1, 16'd1, 8'h3E, 8'hD2}
    };

    initial begin
        #200000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base;
        int p0;
        logic s0;
        wait_cycles(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(sclk == 1'b0 && cs_n == 2'b11 && !tx_pop && !rx_push, "R11 reset",
              {sclk, cs_n, tx_pop, rx_push}, 5'b01100);
        check(busy == 1'b0, "R8 idle busy", busy, 0);

        enable = 1'b1;
        for (int v = 0; v < NV; v++) begin
            int exp_half;
            cpol = VEC[v][33];
            cpha = VEC[v][32];
            clk_div = VEC[v][31:16];
            exp_half = (VEC[v][31:16] >> 1) == 0 ? 1 : int'(VEC[v][31:16] >> 1);
            wait_cycles(2);
            slave_clear();
            s_bytes[0] = VEC[v][7:0];
            base = rx_cnt;
            push_tx(VEC[v][15:8]);
            wait_rx(base + 1, 2000);
            wait_cycles(3);
            check(rx_log[base % 64] == VEC[v][7:0], "R5 R3 received byte", rx_log[base % 64], VEC[v][7:0]);
            check(s_rx[0] == VEC[v][15:8], "R4 MSB-first transmit", s_rx[0], VEC[v][15:8]);
            check(s_edges == 16, "R4 edge count", s_edges, 16);
            check(last_gap == exp_half, "R1 half period", last_gap, exp_half);
            check(sclk == cpol && busy == 1'b0 && rx_cnt == base + 1, "R2 R9 idle after byte",
                  {sclk, busy}, {cpol, 1'b0});
        end

        // R6: chip selects follow mask and enable, independent of frames.
        cs_mask = 2'b01; wait_cycles(2);
        check(cs_n == 2'b10, "R6 select 0", cs_n, 2'b10);
        cs_mask = 2'b10; wait_cycles(2);
        check(cs_n == 2'b01, "R6 select 1", cs_n, 2'b01);
        enable = 1'b0; wait_cycles(2);
        check(cs_n == 2'b11, "R6 disabled", cs_n, 2'b11);
        enable = 1'b1;

        // R9: burst of three bytes in order, busy while pending.
        cpol = 1'b0; cpha = 1'b0; clk_div = 16'd2;
        wait_cycles(2);
        slave_clear();
        s_bytes[0] = 8'h11; s_bytes[1] = 8'h22; s_bytes[2] = 8'h33;
        base = rx_cnt;
        push_tx(8'hC1); push_tx(8'hC2); push_tx(8'hC3);
        wait_cycles(1);
        check(busy == 1'b1, "R8 busy during burst", busy, 1);
        check(cs_n == 2'b01, "R6 frames leave selects", cs_n, 2'b01);
        wait_rx(base + 3, 3000);
        wait_cycles(3);
        check(rx_log[base % 64] == 8'h11 && rx_log[(base + 1) % 64] == 8'h22 &&
              rx_log[(base + 2) % 64] == 8'h33, "R9 burst receive order",
              rx_log[(base + 2) % 64], 8'h33);
        check(s_rx[0] == 8'hC1 && s_rx[1] == 8'hC2 && s_rx[2] == 8'hC3, "R9 burst transmit order",
              s_rx[2], 8'hC3);
        check(rx_cnt == base + 3 && s_edges == 48, "R5 one push per byte", rx_cnt - base, 3);

        // R10: receive FIFO full blocks the start of a frame.
        rx_full = 1'b1;
        slave_clear();
        s_bytes[0] = 8'h5C;
        p0 = pop_cnt;
        base = rx_cnt;
        push_tx(8'h77);
        wait_cycles(40);
        check(pop_cnt == p0 && s_edges == 0, "R10 no start while full", pop_cnt - p0, 0);
        check(busy == 1'b1, "R8 busy with pending byte", busy, 1);
        rx_full = 1'b0;
        wait_rx(base + 1, 2000);
        check(rx_log[base % 64] == 8'h5C, "R10 byte after release", rx_log[base % 64], 8'h5C);

        // R10: receive FIFO fills mid-frame; finished byte waits.
        clk_div = 16'd40;
        wait_cycles(2);
        slave_clear();
        s_bytes[0] = 8'hE7;
        base = rx_cnt;
        push_tx(8'h18);
        wait_cycles(100);
        rx_full = 1'b1;
        wait_cycles(500);
        check(rx_cnt == base && busy == 1'b1 && s_edges == 16, "R10 hold finished frame",
              rx_cnt - base, 0);
        rx_full = 1'b0;
        wait_rx(base + 1, 100);
        check(rx_log[base % 64] == 8'hE7 && rx_cnt == base + 1, "R10 held byte delivered",
              rx_log[base % 64], 8'hE7);

        // R7: disable mid-frame abandons the frame.
        cpol = 1'b1;
        wait_cycles(2);
        slave_clear();
        base = rx_cnt;
        push_tx(8'hAA);
        wait_cycles(70);
        enable = 1'b0;
        @(negedge clk);
        check(sclk == 1'b1, "R7 sclk idle after abort", sclk, 1);
        s0 = sclk;
        wait_cycles(200);
        check(rx_cnt == base && sclk == s0 && busy == 1'b0, "R7 no push after abort",
              rx_cnt - base, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule